// File: doc/BRIEF.md
# Wait-on-Reservation Stall Controller

This block sits beside a hart's issue stage and decides how long the pipeline stays parked in a low-power wait after a wait-on-reservation-set instruction issues. The instruction comes in two flavours, selected by `issue_sto`. The plain flavour waits with no timeout of its own. The short flavour always gives up after a fixed short interval and then completes normally.

While the block is parked, it watches three things. The first is the reservation-set valid flag, which drops when a store hits the set. The second is the raw pending-interrupt vector. Enables are not consulted, so a disabled but pending interrupt still wakes the hart. The third is an `early_end` request, which lets the surrounding core cut the wait short for any reason of its own.

For the plain flavour, the privilege context captured at issue decides whether a bounded deadline applies. The context is the privilege level, the virtualization flag and the two timeout-wait control bits. If a deadline applies and it passes before any wake event, the block reports an illegal-instruction or a virtual-instruction fault instead of completing. Each way out of the wait produces a single one-cycle response pulse.

Top module: `wrs_stall_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `stall`, `done`, `illegal_fault` and `virt_fault` are all low.
- R2: If `rsv_valid` is low in the cycle an issue is sampled, `done` pulses in the next cycle and `stall` never rises.
- R3: If `rsv_valid` is high at issue, `stall` is high from the next cycle. The first sampled cycle with `rsv_valid` low ends it: in the following cycle `stall` is low and `done` pulses.
- R4: Any set bit of `irq_pending` ends a stall exactly as in R3. No enable is involved.
- R5: `early_end` high during a stall ends it exactly as in R3, with a normal completion.
- R6: Short flavour (`issue_sto`=1): with no wake event, `stall` stays high for exactly SHORT_CYC cycles and is followed by a `done` pulse. This flavour never faults, whatever the mode bits are.
- R7: Plain flavour (`issue_sto`=0) with `tw`=1 and `priv` other than M (`priv`=2'b11): with no wake event, `stall` lasts TRAP_CYC cycles and is followed by an `illegal_fault` pulse instead of `done`.
- R8: Plain flavour with `tw`=0, `vtw`=1, `virt`=1 and `priv` U (2'b00) or S (2'b01): with no wake event, `stall` lasts TRAP_CYC cycles and is followed by a `virt_fault` pulse.
- R9: Plain flavour in M mode, or with `tw`=0 and not (`virt`=1 and `vtw`=1): no deadline applies. `stall` stays high past TRAP_CYC cycles until a wake event arrives, and then `done` pulses.
- R10: A wake event sampled in the same cycle as the fault deadline wins. The instruction completes with `done` and no fault.
- R11: An issue sampled while `stall` is high is ignored. Both interval counters restart on every accepted issue, so back-to-back waits each get the full interval.
- R12: `done`, `illegal_fault` and `virt_fault` are one-cycle pulses. At most one is high at a time, and none is high while `stall` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_vld | input | 1 | One-cycle issue of a wait instruction |
| issue_sto | input | 1 | Flavour at issue: 1 short timeout, 0 no timeout |
| rsv_valid | input | 1 | Reservation set still valid |
| irq_pending | input | IRQ_W | Pending interrupt lines, enables not applied |
| early_end | input | 1 | Core request to end the wait now |
| priv | input | 2 | Privilege at issue: 00 U, 01 S, 11 M |
| virt | input | 1 | Virtualized mode at issue |
| tw | input | 1 | Timeout-wait control bit |
| vtw | input | 1 | Virtual timeout-wait control bit |
| stall | output | 1 | Hold the pipeline in low-power wait |
| done | output | 1 | Instruction completes normally |
| illegal_fault | output | 1 | Illegal-instruction fault pulse |
| virt_fault | output | 1 | Virtual-instruction fault pulse |

## Verification
The bench builds the block with SHORT_CYC=6, TRAP_CYC=10 and IRQ_W=8. With these values both interval expiries are reached within a few dozen cycles. It also becomes possible to check a wait that outlives the trap deadline when no deadline applies. Because TRAP_CYC exceeds SHORT_CYC, a short-flavour wait that faulted on the wrong counter would show up as a length mismatch. The narrow interrupt vector still allows a high bit and a low bit to be tried separately.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

    typedef enum logic [1:0] {
        PRIV_U    = 2'b00,
        PRIV_S    = 2'b01,
        PRIV_RSVD = 2'b10,
        PRIV_M    = 2'b11
    } priv_e;

    typedef enum logic {
        WAIT_NTO = 1'b0,
        WAIT_STO = 1'b1
    } flavour_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'b00,
        FLT_ILLEGAL = 2'b01,
        FLT_VIRTUAL = 2'b10
    } fault_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } state_e;

    // Context captured when a wait is accepted
    typedef struct packed {
        flavour_e flavour;
        fault_e   fault;
    } wait_ctx_t;

    // Registered one-cycle responses
    typedef struct packed {
        logic done;
        logic illegal;
        logic virt;
    } resp_t;

    // Fault raised if the bounded deadline passes for the no-timeout flavour
    function automatic fault_e deadline_fault(priv_e p, logic v, logic tw_b, logic vtw_b);
        if (p == PRIV_M)
            return FLT_NONE;
        if (tw_b)
            return FLT_ILLEGAL;
        if (v && vtw_b)
            return FLT_VIRTUAL;
        return FLT_NONE;
    endfunction

endpackage

// File: rtl/wrs_cycle_timer.sv
module wrs_cycle_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (run && (cnt != LAST))
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LAST);

    // Counter saturates at its last value rather than wrapping
    assert_hold_at_limit_R11: assert property (@(posedge clk) disable iff (rst)
        (expired && !restart) |=> (cnt == LAST));

endmodule

// File: rtl/wrs_wake_detect.sv
module wrs_wake_detect #(
    parameter int IRQ_W = 16
) (
    input  logic             rsv_valid,
    input  logic [IRQ_W-1:0] irq_pending,
    input  logic             early_end,
    output logic             wake
);
    // Enables are deliberately ignored: any pending line counts
    assign wake = !rsv_valid || (|irq_pending) || early_end;
endmodule

// File: rtl/wrs_fault_policy.sv
module wrs_fault_policy
    import wrs_pkg::*;
(
    input  flavour_e flavour,
    input  priv_e    priv,
    input  logic     virt,
    input  logic     tw,
    input  logic     vtw,
    output fault_e   fault
);
    always_comb begin
        if (flavour == WAIT_STO)
            fault = FLT_NONE;
        else
            fault = deadline_fault(priv, virt, tw, vtw);
    end
endmodule

// File: rtl/wrs_stall_ctrl.sv
module wrs_stall_ctrl
    import wrs_pkg::*;
#(
    parameter int IRQ_W     = 16,
    parameter int SHORT_CYC = 64,
    parameter int TRAP_CYC  = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_vld,
    input  logic             issue_sto,
    input  logic             rsv_valid,
    input  logic [IRQ_W-1:0] irq_pending,
    input  logic             early_end,
    input  logic [1:0]       priv,
    input  logic             virt,
    input  logic             tw,
    input  logic             vtw,
    output logic             stall,
    output logic             done,
    output logic             illegal_fault,
    output logic             virt_fault
);
    state_e    state;
    wait_ctx_t ctx;
    resp_t     resp;
    fault_e    pol_fault;
    logic      wake;
    logic      accept;
    logic      short_exp;
    logic      trap_exp;

    assign accept = (state == ST_IDLE) && issue_vld;

    wrs_wake_detect #(.IRQ_W(IRQ_W)) u_wake (
        .rsv_valid   (rsv_valid),
        .irq_pending (irq_pending),
        .early_end   (early_end),
        .wake        (wake)
    );

    wrs_fault_policy u_policy (
        .flavour (flavour_e'(issue_sto)),
        .priv    (priv_e'(priv)),
        .virt    (virt),
        .tw      (tw),
        .vtw     (vtw),
        .fault   (pol_fault)
    );

    wrs_cycle_timer #(.LIMIT(SHORT_CYC)) u_short_tmr (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .run     (state == ST_WAIT),
        .expired (short_exp)
    );

    wrs_cycle_timer #(.LIMIT(TRAP_CYC)) u_trap_tmr (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .run     (state == ST_WAIT),
        .expired (trap_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ctx   <= '0;
            resp  <= '0;
        end else begin
            resp <= '0;
            unique case (state)
                ST_IDLE: begin
                    if (issue_vld) begin
                        ctx.flavour <= flavour_e'(issue_sto);
                        ctx.fault   <= pol_fault;
                        if (!rsv_valid)
                            resp.done <= 1'b1;
                        else
                            state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (wake) begin
                        resp.done <= 1'b1;
                        state     <= ST_IDLE;
                    end else if ((ctx.flavour == WAIT_STO) && short_exp) begin
                        resp.done <= 1'b1;
                        state     <= ST_IDLE;
                    end else if ((ctx.flavour == WAIT_NTO) && (ctx.fault != FLT_NONE) && trap_exp) begin
                        unique case (ctx.fault)
                            FLT_ILLEGAL: resp.illegal <= 1'b1;
                            FLT_VIRTUAL: resp.virt    <= 1'b1;
                            default:     resp.done    <= 1'b1;
                        endcase
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign stall         = (state == ST_WAIT);
    assign done          = resp.done;
    assign illegal_fault = resp.illegal;
    assign virt_fault    = resp.virt;

    assert_invalid_at_issue_R2: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && !stall && !rsv_valid) |=> (done && !stall));

    assert_wake_ends_stall_R3: assert property (@(posedge clk) disable iff (rst)
        (stall && wake) |=> (done && !stall));

    assert_short_completes_R6: assert property (@(posedge clk) disable iff (rst)
        (stall && (ctx.flavour == WAIT_STO) && short_exp) |=> (done && !illegal_fault && !virt_fault));

    assert_wake_beats_deadline_R10: assert property (@(posedge clk) disable iff (rst)
        (stall && wake && trap_exp) |=> (!illegal_fault && !virt_fault));

    assert_issue_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (stall && issue_vld && !wake && !short_exp && !trap_exp) |=> stall);

    assert_resp_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, illegal_fault, virt_fault}) && !(stall && (done || illegal_fault || virt_fault)));

    assert_stall_exit_resp_R12: assert property (@(posedge clk) disable iff (rst)
        $fell(stall) |-> (done || illegal_fault || virt_fault));

endmodule

// File: tb/wrs_stall_ctrl_test.sv
module wrs_stall_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int IRQ_W      = 8;
    localparam int SHORT_CYC  = 6;
    localparam int TRAP_CYC   = 10;

    localparam int EV_DONE = 1;
    localparam int EV_ILL  = 2;
    localparam int EV_VIR  = 3;

    localparam int WK_NONE    = 0;
    localparam int WK_RSV     = 1;
    localparam int WK_IRQ     = 2;
    localparam int WK_EARLY   = 3;
    localparam int WK_INVALID = 4;

    typedef struct {
        int    ev;
        int    len;
        string req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             issue_vld = 1'b0;
    logic             issue_sto = 1'b0;
    logic             rsv_valid = 1'b1;
    logic [IRQ_W-1:0] irq_pending = '0;
    logic             early_end = 1'b0;
    logic [1:0]       priv = 2'b00;
    logic             virt = 1'b0;
    logic             tw = 1'b0;
    logic             vtw = 1'b0;
    logic             stall, done, illegal_fault, virt_fault;

    int   n_checks = 0;
    int   n_errors = 0;
    int   run_len  = 0;
    logic finished = 1'b0;
    exp_t expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wrs_stall_ctrl #(
        .IRQ_W(IRQ_W), .SHORT_CYC(SHORT_CYC), .TRAP_CYC(TRAP_CYC)
    ) uut (
        .clk(clk), .rst(rst), .issue_vld(issue_vld), .issue_sto(issue_sto),
        .rsv_valid(rsv_valid), .irq_pending(irq_pending), .early_end(early_end),
        .priv(priv), .virt(virt), .tw(tw), .vtw(vtw),
        .stall(stall), .done(done), .illegal_fault(illegal_fault), .virt_fault(virt_fault)
    );

    task automatic check(input logic ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: measures stall length and pops the scoreboard on each response
    always @(negedge clk) begin
        if (!rst && !finished) begin
            int n;
            int ev;
            n  = int'(done) + int'(illegal_fault) + int'(virt_fault);
            ev = done ? EV_DONE : (illegal_fault ? EV_ILL : (virt_fault ? EV_VIR : 0));
            if (n > 1) check(1'b0, "R12 multiple responses", n, 1);
            if (n > 0 && stall) check(1'b0, "R12 response during stall", 1, 0);
            if (n > 0) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R12 unexpected response", ev, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(ev == e.ev, {e.req, " response kind"}, ev, e.ev);
                    check(run_len == e.len, {e.req, " stall length"}, run_len, e.len);
                end
                run_len = 0;
            end else if (stall) begin
                run_len++;
            end
        end
    end

    // Driver: issue one wait, optionally wake it after w further cycles
    task automatic run_wait(input logic sto, input logic [1:0] p, input logic v,
                            input logic t, input logic vt, input int wk,
                            input int w, input int irq_bit,
                            input int ev, input int len, input string req);
        exp_t e;
        e.ev = ev; e.len = len; e.req = req;
        expq.push_back(e);
        @(negedge clk); #1;
        issue_sto = sto; priv = p; virt = v; tw = t; vtw = vt;
        if (wk == WK_INVALID) rsv_valid = 1'b0;
        issue_vld = 1'b1;
        @(negedge clk); #1;
        issue_vld = 1'b0;
        rsv_valid = 1'b1;
        if (wk == WK_NONE || wk == WK_INVALID) begin
            repeat (len + 3) @(negedge clk);
        end else begin
            repeat (w) @(negedge clk);
            #1;
            check(stall == 1'b1, {req, " still stalled before wake"}, int'(stall), 1);
            if (wk == WK_RSV)   rsv_valid = 1'b0;
            if (wk == WK_IRQ)   irq_pending[irq_bit] = 1'b1;
            if (wk == WK_EARLY) early_end = 1'b1;
            @(negedge clk); #1;
            rsv_valid = 1'b1; irq_pending = '0; early_end = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check({stall, done, illegal_fault, virt_fault} == 4'b0, "R1 outputs in reset",
              int'({stall, done, illegal_fault, virt_fault}), 0);
        #1; rst = 1'b0;
        @(negedge clk);
        check({stall, done, illegal_fault, virt_fault} == 4'b0, "R1 outputs after reset",
              int'({stall, done, illegal_fault, virt_fault}), 0);

        // R2: reservation already invalid at issue
        run_wait(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, WK_INVALID, 0, 0, EV_DONE, 0, "R2");
        run_wait(1'b1, 2'b01, 1'b0, 1'b1, 1'b0, WK_INVALID, 0, 0, EV_DONE, 0, "R2 short");

        // R3: store kills the reservation
        run_wait(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, WK_RSV, 3, 0, EV_DONE, 4, "R3");
        run_wait(1'b0, 2'b01, 1'b0, 1'b1, 1'b0, WK_RSV, 0, 0, EV_DONE, 1, "R3 first cycle");

        // R4: pending interrupt lines, no enable involved
        run_wait(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, WK_IRQ, 2, 5, EV_DONE, 3, "R4 bit5");
        run_wait(1'b0, 2'b11, 1'b0, 1'b1, 1'b0, WK_IRQ, 0, 0, EV_DONE, 1, "R4 bit0");
        run_wait(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, WK_IRQ, 1, IRQ_W-1, EV_DONE, 2, "R4 top bit");

        // R5: early termination request
        run_wait(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, WK_EARLY, 4, 0, EV_DONE, 5, "R5");

        // R6: short timeout, never faults; R11 back-to-back restart
        run_wait(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, WK_NONE, 0, 0, EV_DONE, SHORT_CYC, "R6");
        run_wait(1'b1, 2'b00, 1'b1, 1'b1, 1'b1, WK_NONE, 0, 0, EV_DONE, SHORT_CYC, "R6 with tw");
        run_wait(1'b1, 2'b01, 1'b0, 1'b1, 1'b0, WK_NONE, 0, 0, EV_DONE, SHORT_CYC, "R11 restart");

        // R7: illegal-instruction deadline
        run_wait(1'b0, 2'b01, 1'b0, 1'b1, 1'b0, WK_NONE, 0, 0, EV_ILL, TRAP_CYC, "R7 S");
        run_wait(1'b0, 2'b00, 1'b1, 1'b1, 1'b1, WK_NONE, 0, 0, EV_ILL, TRAP_CYC, "R7 VU tw wins");

        // R8: virtual-instruction deadline
        run_wait(1'b0, 2'b00, 1'b1, 1'b0, 1'b1, WK_NONE, 0, 0, EV_VIR, TRAP_CYC, "R8 VU");
        run_wait(1'b0, 2'b01, 1'b1, 1'b0, 1'b1, WK_NONE, 0, 0, EV_VIR, TRAP_CYC, "R8 VS");

        // R9: no deadline applies, waits past TRAP_CYC
        run_wait(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, WK_IRQ, TRAP_CYC+4, 3, EV_DONE, TRAP_CYC+5, "R9 U");
        run_wait(1'b0, 2'b11, 1'b0, 1'b1, 1'b1, WK_RSV, TRAP_CYC+2, 0, EV_DONE, TRAP_CYC+3, "R9 M");
        run_wait(1'b0, 2'b00, 1'b0, 1'b0, 1'b1, WK_EARLY, TRAP_CYC+1, 0, EV_DONE, TRAP_CYC+2, "R9 non-virt vtw");

        // R10: wake in the deadline cycle wins
        run_wait(1'b0, 2'b01, 1'b0, 1'b1, 1'b0, WK_IRQ, TRAP_CYC-1, 2, EV_DONE, TRAP_CYC, "R10 ill");
        run_wait(1'b0, 2'b00, 1'b1, 1'b0, 1'b1, WK_RSV, TRAP_CYC-1, 0, EV_DONE, TRAP_CYC, "R10 vir");

        // R11: issue during stall is ignored
        begin
            exp_t e;
            e.ev = EV_DONE; e.len = 5; e.req = "R11 ignored issue";
            expq.push_back(e);
            @(negedge clk); #1;
            issue_sto = 1'b0; priv = 2'b00; virt = 1'b0; tw = 1'b0; vtw = 1'b0;
            issue_vld = 1'b1;
            @(negedge clk); #1; issue_vld = 1'b0;
            @(negedge clk); #1; issue_vld = 1'b1; issue_sto = 1'b1;
            @(negedge clk); #1; issue_vld = 1'b0;
            repeat (2) @(negedge clk);
            #1; irq_pending[1] = 1'b1;
            @(negedge clk); #1; irq_pending = '0;
            repeat (SHORT_CYC + 2) @(negedge clk);
            check(stall == 1'b0, "R11 no second wait started", int'(stall), 0);
        end

        repeat (3) @(negedge clk);
        check(expq.size() == 0, "R12 all expected responses seen", expq.size(), 0);
        finish_run();
    end
endmodule